// File: doc/BRIEF.md
# Single-Wire Bus Master Bit Engine

This block drives one open-drain wire that is held high by an external pullup resistor. It carries out the three bit-level operations of the bus. The first is a bus reset, which pulls the line low for a long interval and then checks whether any device answers by pulling the line low. The second is a one-bit write slot. The third is a one-bit read slot. All timing is counted in microseconds, derived from the system clock through a divider set by a parameter.

The user issues one operation at a time. It places a 2-bit operation code (and, for a write, the data bit) on the command inputs, with a valid strobe. The engine raises `busy` for the length of the operation. It ends the operation with a one-cycle `done` pulse, after which `presence` or `rd_bit` hold the result. On the wire side the block only asserts a pull-down enable; the high level always comes from the pullup. The returning line level passes through a two-flop synchronizer before use.

Top module: `swire_master`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `line_pd`, `presence` and `rd_bit` are all 0.
- R2: Operation code 2'b01 (bus reset) asserts `line_pd` for exactly 480 µs. `done` follows 960 µs after the command is accepted.
- R3: During a bus reset, `presence` is loaded with the inverse of the synchronized line level 70 µs after `line_pd` is released. It keeps that value until the next bus reset, so a reset with no answer clears it.
- R4: Operation code 2'b10 with `cmd_wbit`=1 asserts `line_pd` for exactly 6 µs. The slot, including 10 µs of released recovery, ends with `done` 70 µs after acceptance.
- R5: Operation code 2'b10 with `cmd_wbit`=0 asserts `line_pd` for exactly 60 µs, then 10 µs of recovery, with `done` 70 µs after acceptance.
- R6: Operation code 2'b11 (read) asserts `line_pd` for exactly 6 µs. It loads `rd_bit` with the synchronized line level 15 µs after acceptance (1 = line high) and ends with `done` 70 µs after acceptance.
- R7: `busy` rises on the cycle after a command is accepted. It falls in the same cycle that `done` is high, and `done` is high for one cycle only.
- R8: A command presented while `busy` is 1 is ignored, as is operation code 2'b00. Neither produces a slot, a `done` pulse or a change to `presence`/`rd_bit`.
- R9: `line_pd` is never asserted while the engine is idle, and every operation begins with `line_pd` asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken only while idle |
| cmd_op | input | 2 | 01 bus reset, 10 write bit, 11 read bit, 00 no operation |
| cmd_wbit | input | 1 | Data bit for a write command |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| presence | output | 1 | A device answered the last bus reset |
| rd_bit | output | 1 | Bit returned by the last read slot |
| line_pd | output | 1 | Pull-down enable for the open-drain wire (1 = pull low) |
| line_in | input | 1 | Raw level of the wire |

## Verification
The bench builds the engine with `CLK_PER_US` = 2 and keeps the default microsecond timings. At two clocks per microsecond, a whole bus reset lasts under two thousand cycles, so answered and unanswered resets, both write values and both read values run in a short test. Every timing boundary still falls on an exact cycle count, so pulse widths and slot lengths are compared cycle-exact against the microsecond figures. A modelled device on the wire answers resets and pulls read slots low. This exercises the synchronizer path and the sample points, and the command-while-busy cases show that the ignored commands leave the slot untouched.

// File: rtl/swm_pkg.sv
package swm_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_RESET = 2'b01,
    OP_WRITE = 2'b10,
    OP_READ  = 2'b11
  } swm_op_e;
endpackage

// File: rtl/swm_tick.sv
module swm_tick #(
  parameter int DIV = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/swm_sync.sv
module swm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/swm_seq.sv
module swm_seq
  import swm_pkg::*;
#(
  parameter int T_RST_LOW = 480,
  parameter int T_PDET    = 70,
  parameter int T_RCV     = 480,
  parameter int T_W1_LOW  = 6,
  parameter int T_W0_LOW  = 60,
  parameter int T_RD_LOW  = 6,
  parameter int T_RD_SMP  = 15,
  parameter int T_SLOT    = 60,
  parameter int T_REC     = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       line_s,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       cmd_wbit,
  output logic       accept,
  output logic       busy,
  output logic       done,
  output logic       presence,
  output logic       rd_bit,
  output logic       line_pd
);
  localparam int RST_END  = T_RST_LOW + T_RCV;
  localparam int PRES_PT  = T_RST_LOW + T_PDET;
  localparam int SLOT_END = T_SLOT + T_REC;
  localparam int MAXV     = (RST_END > SLOT_END) ? RST_END : SLOT_END;
  localparam int CNT_W    = $clog2(MAXV + 1);

  swm_op_e          op_q;
  logic             bit_q;
  logic [CNT_W-1:0] el;
  logic [CNT_W-1:0] nxt;
  logic [CNT_W-1:0] rel_pt;
  logic [CNT_W-1:0] end_pt;

  assign accept = !busy && cmd_valid && (swm_op_e'(cmd_op) != OP_NONE);
  assign nxt    = el + 1'b1;

  always_comb begin
    unique case (op_q)
      OP_RESET: begin
        rel_pt = CNT_W'(T_RST_LOW);
        end_pt = CNT_W'(RST_END);
      end
      OP_WRITE: begin
        rel_pt = bit_q ? CNT_W'(T_W1_LOW) : CNT_W'(T_W0_LOW);
        end_pt = CNT_W'(SLOT_END);
      end
      default: begin
        rel_pt = CNT_W'(T_RD_LOW);
        end_pt = CNT_W'(SLOT_END);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q     <= OP_NONE;
      bit_q    <= 1'b0;
      el       <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      presence <= 1'b0;
      rd_bit   <= 1'b0;
      line_pd  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        op_q    <= swm_op_e'(cmd_op);
        bit_q   <= cmd_wbit;
        el      <= '0;
        busy    <= 1'b1;
        line_pd <= 1'b1;
      end else if (busy && tick) begin
        el <= nxt;
        if (nxt == rel_pt) line_pd <= 1'b0;
        if (op_q == OP_RESET && nxt == CNT_W'(PRES_PT)) presence <= ~line_s;
        if (op_q == OP_READ && nxt == CNT_W'(T_RD_SMP)) rd_bit <= line_s;
        if (nxt == end_pt) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          line_pd <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/swire_master.sv
module swire_master #(
  parameter int CLK_PER_US = 250,
  parameter int SYNC_STAGES = 2,
  parameter int T_RST_LOW  = 480,
  parameter int T_PDET     = 70,
  parameter int T_RCV      = 480,
  parameter int T_W1_LOW   = 6,
  parameter int T_W0_LOW   = 60,
  parameter int T_RD_LOW   = 6,
  parameter int T_RD_SMP   = 15,
  parameter int T_SLOT     = 60,
  parameter int T_REC      = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       cmd_wbit,
  output logic       busy,
  output logic       done,
  output logic       presence,
  output logic       rd_bit,
  output logic       line_pd,
  input  logic       line_in
);
  logic tick;
  logic line_s;
  logic accept;

  swm_tick #(.DIV(CLK_PER_US)) u_tick (
    .clk (clk),
    .rst (rst),
    .clr (accept),
    .tick(tick)
  );

  swm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (line_in),
    .dout(line_s)
  );

  swm_seq #(
    .T_RST_LOW(T_RST_LOW), .T_PDET(T_PDET), .T_RCV(T_RCV),
    .T_W1_LOW(T_W1_LOW), .T_W0_LOW(T_W0_LOW), .T_RD_LOW(T_RD_LOW),
    .T_RD_SMP(T_RD_SMP), .T_SLOT(T_SLOT), .T_REC(T_REC)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .line_s   (line_s),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .cmd_wbit (cmd_wbit),
    .accept   (accept),
    .busy     (busy),
    .done     (done),
    .presence (presence),
    .rd_bit   (rd_bit),
    .line_pd  (line_pd)
  );
endmodule

// File: rtl/swm_checker.sv
module swm_checker #(
  parameter int CLK_PER_US = 250,
  parameter int T_RST_LOW  = 480,
  parameter int T_W1_LOW   = 6,
  parameter int T_W0_LOW   = 60
) (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic       busy,
  input logic       done,
  input logic       presence,
  input logic       rd_bit,
  input logic       line_pd
);
  logic [31:0] lowcnt;

  always_ff @(posedge clk) begin
    if (rst)          lowcnt <= '0;
    else if (line_pd) lowcnt <= lowcnt + 1;
    else              lowcnt <= '0;
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !line_pd) else $error("idle pull-down"); // R9

  AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> line_pd) else $error("slot not started low"); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done longer than one cycle"); // R7

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))) else $error("done not at busy fall"); // R7

  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_valid) |=> !$rose(line_pd)) else $error("command taken while busy"); // R8

  AST_IDLE_RESULTS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !busy |=> ($stable(presence) && $stable(rd_bit))) else $error("result moved while idle"); // R8

  AST_LOW_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (!line_pd && lowcnt != 0) |->
      (lowcnt == 32'(T_W1_LOW * CLK_PER_US) || lowcnt == 32'(T_W0_LOW * CLK_PER_US) ||
       lowcnt == 32'(T_RST_LOW * CLK_PER_US))) else $error("bad low width"); // R4
endmodule

bind swire_master swm_checker #(
  .CLK_PER_US(CLK_PER_US), .T_RST_LOW(T_RST_LOW),
  .T_W1_LOW(T_W1_LOW), .T_W0_LOW(T_W0_LOW)
) u_swm_checker (
  .clk      (clk),
  .rst      (rst),
  .cmd_valid(cmd_valid),
  .cmd_op   (cmd_op),
  .busy     (busy),
  .done     (done),
  .presence (presence),
  .rd_bit   (rd_bit),
  .line_pd  (line_pd)
);

// File: tb/test_swire_master.sv
module test_swire_master;
  localparam int N = 2;

  typedef struct {
    int    low;
    int    total;
    bit    has_val;
    bit    val;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic       cmd_wbit = 1'b0;
  logic       busy, done, presence, rd_bit, line_pd;
  logic       slave_pd = 1'b0;
  logic       line_in;

  int checks = 0;
  int fails  = 0;
  exp_t q[$];

  assign line_in = !(line_pd | slave_pd);

  always #2 clk = ~clk;

  swire_master #(.CLK_PER_US(N)) i_swire_master (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_wbit(cmd_wbit), .busy(busy), .done(done), .presence(presence),
    .rd_bit(rd_bit), .line_pd(line_pd), .line_in(line_in)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // monitor: measures each operation and compares with the scoreboard
  int  cyc = 0;
  int  start_c = 0;
  int  lowc = 0;
  logic pd_prev = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (line_pd && !pd_prev) begin
      start_c = cyc;
      lowc = 0;
    end
    if (line_pd) lowc++;
    pd_prev = line_pd;
    if (done) begin
      if (q.size() == 0) begin
        check(0, "R8 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(lowc == e.low, {e.tag, " low width"}, lowc, e.low);
        check(cyc - start_c == e.total, {e.tag, " slot length"}, cyc - start_c, e.total);
        if (e.has_val)
          check((e.tag.substr(0, 1) == "R3" ? presence : rd_bit) == e.val,
                {e.tag, " result"},
                (e.tag.substr(0, 1) == "R3" ? presence : rd_bit), e.val);
      end
    end
  end

  task automatic issue(input logic [1:0] op, input logic b);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_wbit = b;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00; cmd_wbit = 1'b0;
  endtask

  task automatic wait_us(input int us);
    repeat (us * N) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    wait_us(2);
  endtask

  task automatic do_reset(input bit answer, input string tag);
    q.push_back('{480 * N, 960 * N, 1'b1, answer, tag});
    issue(2'b01, 1'b0);
    while (line_pd) @(negedge clk);
    if (answer) begin
      wait_us(30);
      slave_pd = 1'b1;
      wait_us(120);
      slave_pd = 1'b0;
    end
    wait_idle();
  endtask

  task automatic do_write(input bit b);
    q.push_back('{(b ? 6 : 60) * N, 70 * N, 1'b0, 1'b0, b ? "R4 write1" : "R5 write0"});
    issue(2'b10, b);
    wait_idle();
  endtask

  task automatic do_read(input bit v);
    q.push_back('{6 * N, 70 * N, 1'b1, v, v ? "R6 read1" : "R6 read0"});
    issue(2'b11, 1'b0);
    if (!v) begin
      slave_pd = 1'b1;
      wait_us(30);
      slave_pd = 1'b0;
    end
    wait_idle();
  endtask

  initial begin
    #2000000;
    check(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(busy == 0, "R1 busy", busy, 0);
    check(done == 0, "R1 done", done, 0);
    check(line_pd == 0, "R1 line_pd", line_pd, 0);
    check(presence == 0, "R1 presence", presence, 0);
    check(rd_bit == 0, "R1 rd_bit", rd_bit, 0);

    // R8 no-operation code ignored
    issue(2'b00, 1'b1);
    wait_us(3);
    check(busy == 0 && line_pd == 0, "R8 op 00 ignored", busy | line_pd, 0);

    do_reset(1'b1, "R3 reset answered");   // R2 timing and presence set
    do_reset(1'b0, "R3 reset silent");     // presence cleared
    do_reset(1'b1, "R3 reset answered again");
    do_write(1'b1);
    do_write(1'b0);
    do_read(1'b1);
    do_read(1'b0);
    do_write(1'b0);
    do_read(1'b1);

    // R8 command during busy: a write0 arrives in the middle of a read1 slot
    q.push_back('{6 * N, 70 * N, 1'b1, 1'b1, "R8 read with busy command"});
    issue(2'b11, 1'b0);
    wait_us(10);
    issue(2'b10, 1'b0);
    // R7 busy remains high throughout the slot
    check(busy == 1, "R7 busy mid slot", busy, 1);
    wait_idle();
    wait_us(100);
    check(q.size() == 0, "R8 no extra operation", q.size(), 0);
    check(line_pd == 0 && busy == 0, "R9 idle released", line_pd | busy, 0);
    check(presence == 1, "R8 presence untouched", presence, 1);

    finish_run();
  end
endmodule